// File: doc/BRIEF.md
# Cache Line Refill Sequencer with Selectable Memory Organization

This block fetches a four-word cache line from a lower memory level and hands it to the cache one return beat at a time. The cycle-by-cycle timing follows the bus organization picked for the request. The narrow organization moves one word per access over a one-word bus. The dual and quad organizations use a memory two or four words wide. The banked organization has four one-word banks on a one-word bus. In the banked organization the four banks start their accesses together, so the line costs a single access latency, and the four words then stream out on consecutive cycles.

A refill starts with a one-cycle address phase. Each memory access then waits a fixed latency (parameter `ACCESS_CYC`, 15 by default), and each return takes one cycle. With the default latency the refill lasts 65 cycles narrow, 33 dual, 17 quad and 20 banked. Word i of every line sits in bank i. The memory itself is four internal register banks that a simple fill port loads one word at a time. Only one refill is in flight at a time.

Top module: `refill_timer`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_wvalid` and `rsp_done` are 0.
- R2: Organization code 0 (narrow) gives four beats. Counting the cycle after acceptance as cycle 1, beat k comes in cycle 1+(ACCESS_CYC+1)*(k+1), that is cycles 17, 33, 49 and 65, and carries lane mask 1<<k.
- R3: Organization code 1 (dual) gives two beats, in cycles 17 and 33, with lane masks 4'b0011 and then 4'b1100.
- R4: Organization code 2 (quad) gives a single beat in cycle 17 with lane mask 4'b1111.
- R5: Organization code 3 (banked) gives four beats on consecutive cycles 17, 18, 19 and 20, and beat k carries lane mask 1<<k.
- R6: Lane i of `rsp_data` (bits i*WORD_W upward) carries word i of the requested line, which is stored in bank i. A lane whose `rsp_wvalid` bit is 0 reads as zero, and words come in ascending order starting from word 0.
- R7: `rsp_done` is 1 exactly in the cycle of the last beat of each refill, once per refill.
- R8: `req_ready` is 0 from the cycle after acceptance until the done cycle, and is 1 again in the cycle after `rsp_done`. A request raised while `req_ready` is 0 is ignored and produces no beats.
- R9: The organization and line are sampled only when the request is accepted. Changes to `req_org` or `req_line` during a refill do not change its beats.
- R10: A fill write (`fill_we`, with the line in `fill_line`, the word in `fill_word` and the value in `fill_data`) replaces that word. A later refill of the line returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request, taken when `req_ready` is 1 |
| req_org | input | 2 | Organization: 0 narrow, 1 dual, 2 quad, 3 banked |
| req_line | input | LINE_AW | Line address of the refill |
| req_ready | output | 1 | Idle, able to accept a request |
| fill_we | input | 1 | Memory word write strobe |
| fill_line | input | LINE_AW | Line written by the fill port |
| fill_word | input | 2 | Word index in the line, which is also the bank |
| fill_data | input | WORD_W | Word value written |
| rsp_wvalid | output | 4 | Per-lane valid of the current beat |
| rsp_data | output | 4*WORD_W | Four word lanes, lane i at bits i*WORD_W |
| rsp_done | output | 1 | Last beat of the refill |

## Verification
A request is accepted on a clock edge. Every beat then has a fixed due cycle measured from that edge: 16 cycles plus 16 per earlier access for the narrow and dual organizations, and 16 plus the beat index for the banked one. The driver computes the due cycle, lane mask, lane data and done flag for each beat when the request is accepted and queues them. The monitor samples on the falling edge. It compares every beat it sees against the head of the queue, counts a beat that arrives with the queue empty as a failure, and counts a queued beat that is still missing after its due cycle as a failure. The monitor also checks that `req_ready` is back to 1 one cycle after each done.

// File: rtl/refill_pkg.sv
package refill_pkg;

    localparam int LINE_WORDS = 4;
    localparam int LANE_IW    = 2;

    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_DUAL   = 2'd1,
        ORG_QUAD   = 2'd2,
        ORG_BANKED = 2'd3
    } org_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_WAIT = 2'd2,
        PH_XFER = 2'd3
    } phase_e;

    typedef struct packed {
        logic                 xfer;
        logic                 last;
        logic [LANE_IW-1:0]   beat;
        org_e                 org;
    } beat_info_t;

    function automatic logic [2:0] beats_of(org_e org);
        case (org)
            ORG_NARROW: beats_of = 3'd4;
            ORG_DUAL:   beats_of = 3'd2;
            ORG_QUAD:   beats_of = 3'd1;
            default:    beats_of = 3'd4;
        endcase
    endfunction

    function automatic logic overlapped(org_e org);
        overlapped = (org == ORG_BANKED);
    endfunction

    function automatic logic [LINE_WORDS-1:0] lane_mask(org_e org, logic [LANE_IW-1:0] beat);
        case (org)
            ORG_DUAL:   lane_mask = beat[0] ? 4'b1100 : 4'b0011;
            ORG_QUAD:   lane_mask = 4'b1111;
            default:    lane_mask = 4'b0001 << beat;
        endcase
    endfunction

endpackage

// File: rtl/refill_seq.sv
module refill_seq
    import refill_pkg::*;
#(
    parameter int LINE_AW    = 4,
    parameter int ACCESS_CYC = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_org,
    input  logic [LINE_AW-1:0] req_line,
    output logic               ready,
    output beat_info_t         info,
    output logic [LINE_AW-1:0] line_q
);
    localparam int CNT_W = (ACCESS_CYC < 2) ? 1 : $clog2(ACCESS_CYC + 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(ACCESS_CYC - 1);

    phase_e             phase;
    org_e               org_q;
    logic [CNT_W-1:0]   wait_cnt;
    logic [LANE_IW-1:0] beat;
    logic               is_last;

    assign is_last = (phase == PH_XFER) &&
                     ({1'b0, beat} == (beats_of(org_q) - 3'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            org_q    <= ORG_NARROW;
            line_q   <= '0;
            wait_cnt <= '0;
            beat     <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        org_q  <= org_e'(req_org);
                        line_q <= req_line;
                        phase  <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    beat     <= '0;
                    wait_cnt <= WAIT_LOAD;
                    phase    <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (wait_cnt == '0) begin
                        phase <= PH_XFER;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                PH_XFER: begin
                    if (is_last) begin
                        phase <= PH_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                        if (!overlapped(org_q)) begin
                            wait_cnt <= WAIT_LOAD;
                            phase    <= PH_WAIT;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ready     = (phase == PH_IDLE);
    assign info.xfer = (phase == PH_XFER);
    assign info.last = is_last;
    assign info.beat = beat;
    assign info.org  = org_q;

endmodule

// File: rtl/refill_bank.sv
module refill_bank #(
    parameter int WORD_W  = 32,
    parameter int LINE_AW = 4
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [LINE_AW-1:0] wr_line,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [LINE_AW-1:0] rd_line,
    output logic [WORD_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << LINE_AW;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_line] <= wr_data;
        end
    end

    assign rd_data = cells[rd_line];

endmodule

// File: rtl/refill_lanes.sv
module refill_lanes
    import refill_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  beat_info_t                   info,
    input  logic [LINE_WORDS*WORD_W-1:0] bank_words,
    output logic [LINE_WORDS-1:0]        wvalid,
    output logic [LINE_WORDS*WORD_W-1:0] data
);
    logic [LINE_WORDS-1:0] mask;

    assign mask   = info.xfer ? lane_mask(info.org, info.beat) : '0;
    assign wvalid = mask;

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_lane
        assign data[i*WORD_W +: WORD_W] =
            mask[i] ? bank_words[i*WORD_W +: WORD_W] : '0;
    end

endmodule

// File: rtl/refill_timer.sv
module refill_timer
    import refill_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LINE_AW    = 4,
    parameter int ACCESS_CYC = 15
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [1:0]                   req_org,
    input  logic [LINE_AW-1:0]           req_line,
    output logic                         req_ready,
    input  logic                         fill_we,
    input  logic [LINE_AW-1:0]           fill_line,
    input  logic [1:0]                   fill_word,
    input  logic [WORD_W-1:0]            fill_data,
    output logic [LINE_WORDS-1:0]        rsp_wvalid,
    output logic [LINE_WORDS*WORD_W-1:0] rsp_data,
    output logic                         rsp_done
);
    beat_info_t                   info;
    logic [LINE_AW-1:0]           line_q;
    logic [LINE_WORDS*WORD_W-1:0] bank_words;

    refill_seq #(
        .LINE_AW   (LINE_AW),
        .ACCESS_CYC(ACCESS_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_org  (req_org),
        .req_line (req_line),
        .ready    (req_ready),
        .info     (info),
        .line_q   (line_q)
    );

    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
        refill_bank #(
            .WORD_W (WORD_W),
            .LINE_AW(LINE_AW)
        ) u_bank (
            .clk    (clk),
            .wr_en  (fill_we && (fill_word == LANE_IW'(b))),
            .wr_line(fill_line),
            .wr_data(fill_data),
            .rd_line(line_q),
            .rd_data(bank_words[b*WORD_W +: WORD_W])
        );
    end

    refill_lanes #(
        .WORD_W(WORD_W)
    ) u_lanes (
        .info      (info),
        .bank_words(bank_words),
        .wvalid    (rsp_wvalid),
        .data      (rsp_data)
    );

    assign rsp_done = info.last;

endmodule

// File: rtl/refill_timer_chk.sv
module refill_timer_chk #(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [3:0]          rsp_wvalid,
    input logic [4*WORD_W-1:0] rsp_data,
    input logic                rsp_done
);
    // R1: reset leaves the block idle and silent
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (req_ready && rsp_wvalid == 4'b0 && !rsp_done));

    // R8: an accepted request makes the block busy
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: no beat while idle
    a_r8_no_beat_idle: assert property (@(posedge clk) disable iff (rst)
        (rsp_wvalid != 4'b0) |-> !req_ready);

    // R7: done comes with data
    a_r7_done_has_data: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (rsp_wvalid != 4'b0));

    // R7: done lasts one cycle and then the block is idle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    // R6: a beat carries one, two or four lanes
    a_r6_lane_count: assert property (@(posedge clk) disable iff (rst)
        ($countones(rsp_wvalid) == 0 || $countones(rsp_wvalid) == 1 ||
         $countones(rsp_wvalid) == 2 || $countones(rsp_wvalid) == 4));

    // R6: no data without a valid lane
    a_r6_quiet_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_wvalid == 4'b0) |-> (rsp_data == '0));

endmodule

bind refill_timer refill_timer_chk #(
    .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_wvalid(rsp_wvalid),
    .rsp_data  (rsp_data),
    .rsp_done  (rsp_done)
);

// File: tb/tb_refill_timer.sv
module tb_refill_timer;
    localparam int WORD_W = 32;
    localparam int LINE_AW = 4;
    localparam int ACC = 15;
    localparam int LINES = 1 << LINE_AW;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [1:0]           req_org = 2'd0;
    logic [LINE_AW-1:0]   req_line = '0;
    logic                 req_ready;
    logic                 fill_we = 1'b0;
    logic [LINE_AW-1:0]   fill_line = '0;
    logic [1:0]           fill_word = 2'd0;
    logic [WORD_W-1:0]    fill_data = '0;
    logic [3:0]           rsp_wvalid;
    logic [4*WORD_W-1:0]  rsp_data;
    logic                 rsp_done;

    refill_timer #(.WORD_W(WORD_W), .LINE_AW(LINE_AW), .ACCESS_CYC(ACC)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_org(req_org),
        .req_line(req_line), .req_ready(req_ready), .fill_we(fill_we),
        .fill_line(fill_line), .fill_word(fill_word), .fill_data(fill_data),
        .rsp_wvalid(rsp_wvalid), .rsp_data(rsp_data), .rsp_done(rsp_done));

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        logic [3:0]  mask;
        logic [4*WORD_W-1:0] data;
        bit          last;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic [WORD_W-1:0] model [LINES][4];
    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit prev_done = 1'b0;
    bit run = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor
    always @(negedge clk) begin
        if (run && !rst) begin
            if (rsp_wvalid != 4'b0 || rsp_done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", $sformatf("unexpected beat cyc=%0d mask=%b actual present expected none",
                                               cyc, rsp_wvalid));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due && rsp_wvalid == e.mask && rsp_data == e.data && rsp_done == e.last,
                          e.tag, $sformatf("cyc=%0d mask=%b done=%0b data=%h expected cyc=%0d mask=%b done=%0b data=%h",
                                           cyc, rsp_wvalid, rsp_done, rsp_data, e.due, e.mask, e.last, e.data));
                end
            end else if (q.size() > 0 && cyc > q[0].due) begin
                exp_t e;
                e = q.pop_front();
                check(1'b0, e.tag, $sformatf("missing beat actual none expected cyc=%0d mask=%b", e.due, e.mask));
            end
            if (prev_done) begin
                check(req_ready == 1'b1, "R8",
                      $sformatf("ready after done actual=%0b expected=1", req_ready));
            end
            prev_done <= rsp_done;
        end
    end

    function automatic logic [4*WORD_W-1:0] lanes(int line, logic [3:0] m);
        logic [4*WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) v[i*WORD_W +: WORD_W] = model[line][i];
        end
        return v;
    endfunction

    task automatic push_beat(int due, logic [3:0] m, int line, bit last, string tag);
        exp_t e;
        e.due = due; e.mask = m; e.data = lanes(line, m); e.last = last; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic refill(int org, int line, string tag);
        int acc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_org   = 2'(org);
        req_line  = LINE_AW'(line);
        @(posedge clk);
        #1;
        acc = cyc;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", $sformatf("busy after accept actual=%0b expected=0", req_ready));
        case (org)
            0: for (int k = 0; k < 4; k++)
                   push_beat(acc + (ACC + 1) * (k + 1), 4'b0001 << k, line, k == 3, {tag, " R2 R6 R7"});
            1: for (int k = 0; k < 2; k++)
                   push_beat(acc + (ACC + 1) * (k + 1), (k == 0) ? 4'b0011 : 4'b1100, line, k == 1, {tag, " R3 R6 R7"});
            2: push_beat(acc + ACC + 1, 4'b1111, line, 1'b1, {tag, " R4 R6 R7"});
            default: for (int k = 0; k < 4; k++)
                   push_beat(acc + ACC + 1 + k, 4'b0001 << k, line, k == 3, {tag, " R5 R6 R7"});
        endcase
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(int line, int word, logic [WORD_W-1:0] val);
        @(negedge clk);
        fill_we = 1'b1; fill_line = LINE_AW'(line); fill_word = 2'(word); fill_data = val;
        @(negedge clk);
        fill_we = 1'b0;
        model[line][word] = val;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_wvalid == 4'b0 && rsp_done == 1'b0, "R1",
              $sformatf("ready=%0b wvalid=%b done=%0b expected 1,0000,0", req_ready, rsp_wvalid, rsp_done));
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < 4; w++)
                fill(l, w, 32'hC0DE_0000 | (l << 8) | (w << 4) | (l ^ w));
        run = 1'b1;

        refill(0, 3, "narrow");
        drain();
        refill(1, 5, "dual");
        drain();
        refill(2, 15, "quad");
        drain();
        refill(3, 0, "banked");
        drain();

        // R8 R9: requests and selector changes while busy are ignored
        refill(3, 9, "banked-busy R9");
        req_org = 2'd0; req_line = 4'd2;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            check(req_ready == 1'b0, "R8", $sformatf("ready while busy actual=%0b expected=0", req_ready));
        end
        @(negedge clk);
        req_valid = 1'b0;
        drain();

        refill(0, 7, "narrow-mid R9");
        repeat (20) @(negedge clk);
        req_org = 2'd2; req_line = 4'd1;
        drain();

        // back to back: second request accepted right after done
        refill(2, 4, "b2b-a");
        refill(1, 6, "b2b-b");
        drain();

        // R10: fill overwrites a word
        fill(15, 2, 32'hFEED_BEEF);
        refill(2, 15, "refill-after-fill R10");
        drain();
        fill(8, 0, 32'h1234_5678);
        refill(3, 8, "banked-after-fill R10");
        drain();

        finish_run();
    end

endmodule